// File: doc/BRIEF.md
# Address-to-Port Route Decoder with Recently-Used Range Cache

This block turns a request address into the number of the output port that owns it. Software-visible routing is held in a table of address windows. Each window has an inclusive low and high bound, a target port number and an enable. One port may own several windows.

A three-slot cache of recently resolved windows sits in front of the table. A request that falls in a cached window is answered on the clock edge after it is accepted. A request that misses the cache stalls the input for one cycle while the whole table is searched. The window that matched is then pushed onto the newest slot of the cache, the older slots shift down, and the oldest is dropped. A hit does not reorder the cache.

An address that no enabled window claims goes to a fallback port. In strict fallback mode the fallback port owns only its own window; an unclaimed address outside that window returns an error instead of a port. Fallback results are never cached. The cache is emptied at reset, on an explicit flush pulse, and on every table write.

Top module: `route_decoder`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and the cache is empty, so the first request of any window takes the miss path.
- R2: A request accepted (`req_valid` and `req_ready` high at a rising edge) whose address lies in a valid cache slot gives `rsp_valid` high with the slot's port and `rsp_err` 0 right after that same edge (latency 1).
- R3: A request that misses the cache drives `req_ready` low for one cycle, and the table result appears one edge later (latency 2).
- R4: After a miss resolved by a table window, later requests anywhere in that window hit the cache (latency 1).
- R5: An insert writes slot 0, moves slot 0 to slot 1 and slot 1 to slot 2, and drops slot 2; a hit does not change the order, so the fourth distinct window inserted evicts the first even if the first was hit meanwhile.
- R6: When several enabled windows contain the address, the one with the lowest table index supplies the port.
- R7: An address claimed by no enabled window, with `dflt_strict` 0, returns `dflt_port` with `rsp_err` 0 through the miss path every time (never cached).
- R8: With `dflt_strict` 1, an unclaimed address inside [`dflt_base`, `dflt_limit`] returns `dflt_port`, and one outside it returns `rsp_err` 1 with `rsp_port` 0.
- R9: A `flush` pulse invalidates all three cache slots; the next request to a formerly cached window takes the miss path.
- R10: A table write (`cfg_we`) empties the cache, and the rewritten window's new port is used from the next request.
- R11: Window bounds are inclusive: the low and high bounds match, the addresses just outside do not.
- R12: A table entry written with `cfg_enable` 0 claims no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_port | output | PORT_W | Resolved port number |
| rsp_err | output | 1 | Address rejected in strict fallback mode |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry index |
| cfg_base | input | ADDR_W | Window low bound (inclusive) |
| cfg_limit | input | ADDR_W | Window high bound (inclusive) |
| cfg_port | input | PORT_W | Window target port |
| cfg_enable | input | 1 | Window enable |
| flush | input | 1 | Invalidate all cache slots |
| dflt_port | input | PORT_W | Fallback port |
| dflt_strict | input | 1 | Restrict fallback to its own window |
| dflt_base | input | ADDR_W | Fallback window low bound |
| dflt_limit | input | ADDR_W | Fallback window high bound |

## Verification
The hardest behaviour to reach from the ports is the cache replacement order, since the slot contents are only visible as response latency. The stimulus fills the cache with three windows through misses, hits the oldest one, then forces a fourth miss, and proves by latency that the hit window was still evicted while the two younger ones still answer in one cycle. Overlapping windows are checked with a cold cache so that the table priority, not a cached slot, decides the port.

// File: rtl/route_pkg.sv
// Shared types for the route decoder.
package route_pkg;
    // Controller phase: idle accepts requests, search resolves a cache miss.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } route_state_e;
endpackage

// File: rtl/route_range_table.sv
// Full routing table: NUM_WIN windows with inclusive bounds, target port and
// enable. Lookup is combinational; the lowest matching index wins.
// Assumes windows are normally disjoint; overlap is resolved by priority.
module route_range_table #(
    parameter int ADDR_W  = 32,
    parameter int PORT_W  = 3,
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              wr_enable,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [PORT_W-1:0] look_port,
    output logic [ADDR_W-1:0] look_base,
    output logic [ADDR_W-1:0] look_limit
);
    logic [ADDR_W-1:0] base_q  [NUM_WIN];
    logic [ADDR_W-1:0] limit_q [NUM_WIN];
    logic [PORT_W-1:0] port_q  [NUM_WIN];
    logic [NUM_WIN-1:0] en_q;
    logic [NUM_WIN-1:0] match;

    // Per-entry storage, written by index.
    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_win
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_q[g]  <= '0;
                    limit_q[g] <= '0;
                    port_q[g]  <= '0;
                    en_q[g]    <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    base_q[g]  <= wr_base;
                    limit_q[g] <= wr_limit;
                    port_q[g]  <= wr_port;
                    en_q[g]    <= wr_enable;
                end
            end
            assign match[g] = en_q[g] && (look_addr >= base_q[g]) &&
                              (look_addr <= limit_q[g]);
        end
    endgenerate

    // Priority select: scanning downward leaves the lowest match last.
    always_comb begin
        look_hit   = 1'b0;
        look_port  = '0;
        look_base  = '0;
        look_limit = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                look_hit   = 1'b1;
                look_port  = port_q[i];
                look_base  = base_q[i];
                look_limit = limit_q[i];
            end
        end
    end
endmodule

// File: rtl/route_mru_cache.sv
// Small shift-ordered cache of recently resolved windows. Probe is
// combinational, lowest slot first. An insert enters slot 0 and shifts the
// rest down, dropping the last slot. Flush has priority over insert.
// Assumes the caller inserts only windows that are not already cached.
module route_mru_cache #(
    parameter int ADDR_W = 32,
    parameter int PORT_W = 3,
    parameter int SLOTS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic [PORT_W-1:0] probe_port,
    input  logic              ins_en,
    input  logic [ADDR_W-1:0] ins_base,
    input  logic [ADDR_W-1:0] ins_limit,
    input  logic [PORT_W-1:0] ins_port,
    output logic [SLOTS-1:0]  slot_valid
);
    logic [ADDR_W-1:0] base_q  [SLOTS];
    logic [ADDR_W-1:0] limit_q [SLOTS];
    logic [PORT_W-1:0] port_q  [SLOTS];
    logic [SLOTS-1:0]  vld_q;
    logic [SLOTS-1:0]  hit_vec;

    assign slot_valid = vld_q;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            assign hit_vec[g] = vld_q[g] && (probe_addr >= base_q[g]) &&
                                (probe_addr <= limit_q[g]);
            if (g == 0) begin : g_head
                // Head slot takes the newly inserted window.
                always_ff @(posedge clk) begin
                    if (!rst_n || flush) begin
                        vld_q[g] <= 1'b0;
                    end else if (ins_en) begin
                        vld_q[g] <= 1'b1;
                    end
                    if (rst_n && !flush && ins_en) begin
                        base_q[g]  <= ins_base;
                        limit_q[g] <= ins_limit;
                        port_q[g]  <= ins_port;
                    end
                end
            end else begin : g_tail
                // Older slots take their younger neighbour on insert.
                always_ff @(posedge clk) begin
                    if (!rst_n || flush) begin
                        vld_q[g] <= 1'b0;
                    end else if (ins_en) begin
                        vld_q[g] <= vld_q[g-1];
                    end
                    if (rst_n && !flush && ins_en) begin
                        base_q[g]  <= base_q[g-1];
                        limit_q[g] <= limit_q[g-1];
                        port_q[g]  <= port_q[g-1];
                    end
                end
            end
        end
    endgenerate

    // First valid slot in probe order supplies the port.
    always_comb begin
        probe_hit  = 1'b0;
        probe_port = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                probe_hit  = 1'b1;
                probe_port = port_q[i];
            end
        end
    end
endmodule

// File: rtl/route_decoder.sv
// Top of the route decoder. Accepts one address per handshake, answers a
// cache hit on the next edge, and on a miss stalls one cycle to search the
// full table, then caches the matching window. Unclaimed addresses use the
// fallback port, optionally limited to its own window with an error flag.
// Assumes configuration and fallback inputs are steady while a miss resolves.
module route_decoder #(
    parameter int ADDR_W     = 32,
    parameter int PORT_W     = 3,
    parameter int NUM_WIN    = 8,
    parameter int CACHE_SLOTS = 3,
    localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PORT_W-1:0] rsp_port,
    output logic              rsp_err,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [PORT_W-1:0] cfg_port,
    input  logic              cfg_enable,
    input  logic              flush,
    input  logic [PORT_W-1:0] dflt_port,
    input  logic              dflt_strict,
    input  logic [ADDR_W-1:0] dflt_base,
    input  logic [ADDR_W-1:0] dflt_limit
);
    import route_pkg::*;

    route_state_e      state_q;
    logic [ADDR_W-1:0] hold_addr_q;
    logic              accept;
    logic              c_hit;
    logic [PORT_W-1:0] c_port;
    logic              t_hit;
    logic [PORT_W-1:0] t_port;
    logic [ADDR_W-1:0] t_base;
    logic [ADDR_W-1:0] t_limit;
    logic              ins_en;
    logic              cache_clr;
    logic [CACHE_SLOTS-1:0] slot_valid;
    logic              in_dflt_win;

    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign ins_en      = (state_q == ST_SEARCH) && t_hit;
    assign cache_clr   = flush || cfg_we;
    assign in_dflt_win = (hold_addr_q >= dflt_base) && (hold_addr_q <= dflt_limit);

    route_mru_cache #(
        .ADDR_W (ADDR_W),
        .PORT_W (PORT_W),
        .SLOTS  (CACHE_SLOTS)
    ) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cache_clr),
        .probe_addr (req_addr),
        .probe_hit  (c_hit),
        .probe_port (c_port),
        .ins_en     (ins_en),
        .ins_base   (t_base),
        .ins_limit  (t_limit),
        .ins_port   (t_port),
        .slot_valid (slot_valid)
    );

    route_range_table #(
        .ADDR_W  (ADDR_W),
        .PORT_W  (PORT_W),
        .NUM_WIN (NUM_WIN)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_base    (cfg_base),
        .wr_limit   (cfg_limit),
        .wr_port    (cfg_port),
        .wr_enable  (cfg_enable),
        .look_addr  (hold_addr_q),
        .look_hit   (t_hit),
        .look_port  (t_port),
        .look_base  (t_base),
        .look_limit (t_limit)
    );

    // Request sequencing and registered result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hold_addr_q <= '0;
            rsp_valid   <= 1'b0;
            rsp_port    <= '0;
            rsp_err     <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (c_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_port  <= c_port;
                            rsp_err   <= 1'b0;
                        end else begin
                            state_q     <= ST_SEARCH;
                            hold_addr_q <= req_addr;
                        end
                    end
                end
                default: begin
                    state_q   <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    if (t_hit) begin
                        rsp_port <= t_port;
                        rsp_err  <= 1'b0;
                    end else if (dflt_strict && !in_dflt_win) begin
                        rsp_port <= '0;
                        rsp_err  <= 1'b1;
                    end else begin
                        rsp_port <= dflt_port;
                        rsp_err  <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/route_decoder_checker.sv
// Temporal checks for the route decoder, bound to every instance of the top.
module route_decoder_checker #(
    parameter int PORT_W = 3,
    parameter int SLOTS  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [PORT_W-1:0] rsp_port,
    input logic              rsp_err,
    input logic              c_hit,
    input logic              cache_clr,
    input logic [SLOTS-1:0]  slot_valid
);
    // R2: an accepted hit answers on the next edge.
    p_hit_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && c_hit) |=> (rsp_valid && req_ready));

    // R3: an accepted miss stalls the input for a cycle.
    p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !c_hit) |=> (!req_ready && !rsp_valid));

    // R3: the stall lasts exactly one cycle and ends with a result.
    p_stall_resolves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (rsp_valid && req_ready));

    // R9: a flush leaves every slot invalid.
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cache_clr |=> (slot_valid == '0));

    // R8: an error result carries port zero.
    p_err_port_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_port == '0));

    // R1: no result without a preceding request or search.
    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !rsp_valid);
endmodule

bind route_decoder route_decoder_checker #(
    .PORT_W (PORT_W),
    .SLOTS  (CACHE_SLOTS)
) u_route_decoder_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_port   (rsp_port),
    .rsp_err    (rsp_err),
    .c_hit      (c_hit),
    .cache_clr  (cache_clr),
    .slot_valid (slot_valid)
);

// File: tb/route_decoder_bench.sv
// Scoreboard bench: the driver queues the expected port, error and latency of
// each request; the monitor compares them against every result strobe.
module route_decoder_bench;
    localparam int AW = 32;
    localparam int PW = 3;
    localparam int NW = 8;
    localparam int IW = 3;

    typedef struct {
        logic [PW-1:0] port;
        logic          err;
        int            lat;
        int            acc_cyc;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [PW-1:0] rsp_port;
    logic          rsp_err;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_limit = '0;
    logic [PW-1:0] cfg_port = '0;
    logic          cfg_enable = 1'b0;
    logic          flush = 1'b0;
    logic [PW-1:0] dflt_port = 3'd7;
    logic          dflt_strict = 1'b0;
    logic [AW-1:0] dflt_base = 32'h8000;
    logic [AW-1:0] dflt_limit = 32'h8FFF;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb[$];

    route_decoder #(.ADDR_W(AW), .PORT_W(PW), .NUM_WIN(NW), .CACHE_SLOTS(3)) u_route_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_port(rsp_port),
        .rsp_err(rsp_err), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_port(cfg_port), .cfg_enable(cfg_enable),
        .flush(flush), .dflt_port(dflt_port), .dflt_strict(dflt_strict),
        .dflt_base(dflt_base), .dflt_limit(dflt_limit)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare one expectation per result strobe.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected result port=%0d err=%0d expected none", rsp_port, rsp_err);
            end else begin
                exp_t e;
                int   lat;
                e   = sb.pop_front();
                lat = cyc - e.acc_cyc + 1;
                if (rsp_port !== e.port || rsp_err !== e.err || lat != e.lat) begin
                    n_fail++;
                    $display("FAIL %s port=%0d err=%0d lat=%0d expected port=%0d err=%0d lat=%0d",
                             e.tag, rsp_port, rsp_err, lat, e.port, e.err, e.lat);
                end
            end
        end
    end

    // Driver: issue one request (called at a falling edge) and queue its expectation.
    task automatic send(input logic [AW-1:0] a, input logic [PW-1:0] p,
                        input logic er, input int lat, input string tag);
        exp_t e;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        e.port = p; e.err = er; e.lat = lat; e.acc_cyc = cyc + 1; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] l,
                             input logic [PW-1:0] p, input logic en);
        drain();
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_base = b; cfg_limit = l;
        cfg_port = p; cfg_enable = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_flush();
        drain();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset.
        n_chk++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 ready=%0d valid=%0d expected ready=1 valid=0", req_ready, rsp_valid);
        end

        cfg_write(0, 32'h1000, 32'h1FFF, 3'd1, 1'b1);
        cfg_write(1, 32'h2000, 32'h2FFF, 3'd2, 1'b1);
        cfg_write(2, 32'h3000, 32'h3FFF, 3'd3, 1'b1);
        cfg_write(3, 32'h4000, 32'h4FFF, 3'd4, 1'b1);
        cfg_write(4, 32'h1800, 32'h18FF, 3'd5, 1'b1);
        cfg_write(5, 32'h5000, 32'h5FFF, 3'd6, 1'b0);

        send(32'h1000, 3'd1, 1'b0, 2, "R1 R3 R11 cold miss at low bound");
        send(32'h1FFF, 3'd1, 1'b0, 1, "R2 R4 R11 hit at high bound");
        do_flush();
        send(32'h1880, 3'd1, 1'b0, 2, "R6 R9 overlap after flush");

        // Cache now [w0]; fill with w1, w2 then hit w0.
        send(32'h2000, 3'd2, 1'b0, 2, "R3 miss w1");
        send(32'h3000, 3'd3, 1'b0, 2, "R3 miss w2");
        send(32'h1234, 3'd1, 1'b0, 1, "R5 hit oldest");
        send(32'h4000, 3'd4, 1'b0, 2, "R5 fourth insert");
        send(32'h2500, 3'd2, 1'b0, 1, "R5 w1 still cached");
        send(32'h3500, 3'd3, 1'b0, 1, "R5 w2 still cached");
        send(32'h1000, 3'd1, 1'b0, 2, "R5 oldest evicted");

        send(32'h5000, 3'd7, 1'b0, 2, "R12 disabled entry");
        send(32'h9000, 3'd7, 1'b0, 2, "R7 unclaimed");
        send(32'h9000, 3'd7, 1'b0, 2, "R7 fallback not cached");
        send(32'h0FFF, 3'd7, 1'b0, 2, "R11 below low bound");

        drain();
        dflt_strict = 1'b1;
        send(32'h9000, 3'd0, 1'b1, 2, "R8 outside fallback window");
        send(32'h8000, 3'd7, 1'b0, 2, "R8 fallback low bound");
        send(32'h8FFF, 3'd7, 1'b0, 2, "R8 fallback high bound");
        send(32'h2000, 3'd2, 1'b0, 2, "R8 table still wins");
        drain();
        dflt_strict = 1'b0;

        cfg_write(1, 32'h2000, 32'h2FFF, 3'd6, 1'b1);
        send(32'h1000, 3'd1, 1'b0, 2, "R10 cache emptied by write");
        send(32'h2100, 3'd6, 1'b0, 2, "R10 new port used");
        send(32'h2200, 3'd6, 1'b0, 1, "R4 rewritten window cached");

        drain();
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R3 pending=%0d expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule